// File: doc/BRIEF.md
# Keystream Resynchronization Tracker

This block sits beside the fetch stage of a core whose instructions are stored XOR-masked with a stream-cipher keystream. Each encrypted block of code starts at the target of a taken jump. The keystream for a word depends only on the block start and on how many words into the block it lies. The tracker keeps the start address of the live block. From it, the tracker derives the current word offset. It also steps the fetch side through a re-keying sequence each time a new block begins.

When an exception is taken, the tracker copies the interrupted block start into a shadow register and treats the handler address as a new block. On return, it redirects fetch to the saved block start and has the cipher re-keyed. It then drops the words in front of the resume point, so the keystream position is rebuilt without any cipher state being stored. Software can read and write the shadow register through control-register moves to save it across a context switch. A write is used only by the following return.

The sequence after any restart runs in a fixed order. First, `IV_WORDS` inline IV words are consumed. Then the cipher is re-keyed. Then the block waits for the cipher to report ready. Then it drops the remaining offset words. After that, fetched words are released to decode.

Top module: `ks_resync_tracker`

## Requirements
- R1: After reset `block_base` and `csr_rdata` are 0, `redirect_valid` and `cipher_rekey` are 0, and the block is in the run state, so `word_release` equals `word_valid`.
- R2: A taken jump that has no exception entry or return in the same cycle loads `jump_target` into `block_base` on the next cycle and starts a restart sequence.
- R3: `cur_offset` always equals `(pc - block_base) >> 2`, truncated to `OFFW` bits.
- R4: On exception entry, `block_base` takes `exc_vector` on the next cycle, `csr_rdata` takes the `block_base` value from before the entry, and a restart sequence starts.
- R5: Exception entry has priority over a taken jump in the same cycle. The jump target is ignored.
- R6: A control-register write (`csr_we`) updates `csr_rdata` on the next cycle and leaves `block_base` unchanged.
- R7: On exception return, `block_base` and `redirect_addr` take the shadow value from before the edge, and `redirect_valid` pulses for exactly one cycle. A write in the same cycle as the return is seen only by later returns.
- R8: After a restart, exactly `IV_WORDS` (default 2) fetched words are dropped. Then `cipher_rekey` pulses for one cycle. No word is released or dropped until `cipher_ready` is seen high in a later cycle.
- R9: After a return, once the cipher is ready, `max(0, off - IV_WORDS)` further words are dropped before release starts. Here `off = (exc_pc - shadow) >> 2`.
- R10: `word_release` is high only for a valid word in the run state. `word_discard` is high only for a valid word while IV words or offset words are being dropped. The two are never high together.
- R11: A new restart during a running sequence abandons it and starts the sequence over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| jump_taken | input | 1 | A jump is taken this cycle |
| jump_target | input | AW | Destination of the taken jump |
| exc_enter | input | 1 | Exception entry this cycle |
| exc_vector | input | AW | Handler address |
| exc_return | input | 1 | Return from exception this cycle |
| exc_pc | input | AW | Address at which execution resumes |
| pc | input | AW | Current fetch address |
| word_valid | input | 1 | A fetched word is present |
| cipher_ready | input | 1 | Cipher has finished initialization |
| csr_we | input | 1 | Software write to the shadow register |
| csr_wdata | input | AW | Value written by software |
| csr_rdata | output | AW | Shadow register read value |
| block_base | output | AW | Start address of the live block (keying input) |
| cur_offset | output | OFFW | Word offset of `pc` in the live block |
| redirect_valid | output | 1 | Fetch must restart at `redirect_addr` |
| redirect_addr | output | AW | Restart address |
| cipher_rekey | output | 1 | Re-initialize the cipher from `block_base` |
| word_release | output | 1 | Present word goes to decode |
| word_discard | output | 1 | Present word is dropped |

## Verification
The conflict that matters most is a taken jump and an exception entry landing in the same cycle. Exception entry must win, and the shadow must capture the old block, not the jump target. The bench raises both pulses together and then checks the base, the shadow and the restart sequence against its model. A second overlap is a software write issued in the same cycle as a return. The bench checks that the redirect uses the old shadow value and that the write still appears in the register afterwards.

// File: rtl/ks_resync_pkg.sv
package ks_resync_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_IVLD = 2'd1,
        ST_WAIT = 2'd2,
        ST_SKIP = 2'd3
    } rs_state_e;

endpackage

// File: rtl/ks_word_offset.sv
module ks_word_offset #(
    parameter int AW   = 32,
    parameter int OFFW = 12
) (
    input  logic [AW-1:0]   addr,
    input  logic [AW-1:0]   base,
    output logic [OFFW-1:0] offset
);
    logic [AW-1:0] diff;
    logic          unused_bits;

    assign diff        = addr - base;
    assign offset      = diff[OFFW+1:2];
    assign unused_bits = ^diff;
endmodule

// File: rtl/ks_replay_seq.sv
module ks_replay_seq
    import ks_resync_pkg::*;
#(
    parameter int IV_WORDS = 2,
    parameter int OFFW     = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            start_redir,
    input  logic [OFFW-1:0] start_skip,
    input  logic            word_valid,
    input  logic            cipher_ready,
    output logic            redir_o,
    output logic            rekey_o,
    output logic            rel_o,
    output logic            disc_o
);
    localparam int IVCW = (IV_WORDS > 1) ? $clog2(IV_WORDS) : 1;
    localparam logic [IVCW-1:0] IV_LOAD = IVCW'((IV_WORDS > 0) ? IV_WORDS - 1 : 0);
    localparam rs_state_e ENTRY_ST = (IV_WORDS > 0) ? ST_IVLD : ST_WAIT;
    localparam logic REKEY_AT_START = (IV_WORDS == 0);

    typedef struct packed {
        rs_state_e       st;
        logic [IVCW-1:0] iv_cnt;
        logic [OFFW-1:0] skip;
        logic            rekey;
        logic            redir;
    } seq_t;

    seq_t seq_q, seq_d;
    logic iv_last;

    generate
        if (IV_WORDS == 0) begin : g_ctr_iv
            assign iv_last = 1'b1;
        end else begin : g_inline_iv
            assign iv_last = (seq_q.iv_cnt == '0);
        end
    endgenerate

    always_comb begin
        seq_d       = seq_q;
        seq_d.rekey = 1'b0;
        seq_d.redir = 1'b0;
        if (start) begin
            seq_d.st     = ENTRY_ST;
            seq_d.iv_cnt = IV_LOAD;
            seq_d.skip   = start_skip;
            seq_d.rekey  = REKEY_AT_START;
            seq_d.redir  = start_redir;
        end else begin
            unique case (seq_q.st)
                ST_IVLD: if (word_valid) begin
                    if (iv_last) begin
                        seq_d.st    = ST_WAIT;
                        seq_d.rekey = 1'b1;
                    end else begin
                        seq_d.iv_cnt = seq_q.iv_cnt - 1'b1;
                    end
                end
                ST_WAIT: if (cipher_ready && !seq_q.rekey) begin
                    seq_d.st = (seq_q.skip == '0) ? ST_RUN : ST_SKIP;
                end
                ST_SKIP: if (word_valid) begin
                    seq_d.skip = seq_q.skip - 1'b1;
                    if (seq_q.skip == OFFW'(1)) seq_d.st = ST_RUN;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign redir_o = seq_q.redir;
    assign rekey_o = seq_q.rekey;
    assign rel_o   = word_valid && (seq_q.st == ST_RUN);
    assign disc_o  = word_valid && ((seq_q.st == ST_IVLD) || (seq_q.st == ST_SKIP));

    AST_NO_RELEASE_AFTER_REKEY: assert property (@(posedge clk) disable iff (!rst_n)
        rekey_o |=> !rel_o);  // R8
    AST_RELEASE_DISCARD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rel_o && disc_o));  // R10
endmodule

// File: rtl/ks_resync_tracker.sv
module ks_resync_tracker #(
    parameter int AW       = 32,
    parameter int OFFW     = 12,
    parameter int IV_WORDS = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            jump_taken,
    input  logic [AW-1:0]   jump_target,
    input  logic            exc_enter,
    input  logic [AW-1:0]   exc_vector,
    input  logic            exc_return,
    input  logic [AW-1:0]   exc_pc,
    input  logic [AW-1:0]   pc,
    input  logic            word_valid,
    input  logic            cipher_ready,
    input  logic            csr_we,
    input  logic [AW-1:0]   csr_wdata,
    output logic [AW-1:0]   csr_rdata,
    output logic [AW-1:0]   block_base,
    output logic [OFFW-1:0] cur_offset,
    output logic            redirect_valid,
    output logic [AW-1:0]   redirect_addr,
    output logic            cipher_rekey,
    output logic            word_release,
    output logic            word_discard
);
    localparam logic [OFFW-1:0] IV_OFF = OFFW'(IV_WORDS);

    typedef struct packed {
        logic [AW-1:0] base;
        logic [AW-1:0] shadow;
    } trk_t;

    trk_t            trk_q, trk_d;
    logic            evt_ret, start;
    logic [OFFW-1:0] resume_off, start_skip;

    ks_word_offset #(.AW(AW), .OFFW(OFFW)) u_cur_off (
        .addr(pc), .base(trk_q.base), .offset(cur_offset)
    );

    ks_word_offset #(.AW(AW), .OFFW(OFFW)) u_res_off (
        .addr(exc_pc), .base(trk_q.shadow), .offset(resume_off)
    );

    always_comb begin
        trk_d   = trk_q;
        evt_ret = exc_return && !exc_enter;
        start   = exc_enter || exc_return || jump_taken;
        if (exc_enter)       trk_d.base = exc_vector;
        else if (exc_return) trk_d.base = trk_q.shadow;
        else if (jump_taken) trk_d.base = jump_target;
        if (exc_enter)       trk_d.shadow = trk_q.base;
        else if (csr_we)     trk_d.shadow = csr_wdata;
        start_skip = (evt_ret && (resume_off > IV_OFF)) ? (resume_off - IV_OFF) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    ks_replay_seq #(.IV_WORDS(IV_WORDS), .OFFW(OFFW)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .start(start), .start_redir(evt_ret), .start_skip(start_skip),
        .word_valid(word_valid), .cipher_ready(cipher_ready),
        .redir_o(redirect_valid), .rekey_o(cipher_rekey),
        .rel_o(word_release), .disc_o(word_discard)
    );

    assign block_base    = trk_q.base;
    assign csr_rdata     = trk_q.shadow;
    assign redirect_addr = trk_q.base;

    AST_JUMP_LOADS_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        (jump_taken && !exc_enter && !exc_return) |=> block_base == $past(jump_target));  // R2
    AST_EXC_SAVES_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        exc_enter |=> (block_base == $past(exc_vector)) && (csr_rdata == $past(block_base)));  // R4
    AST_CSR_WRITE_DEFERRED: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && !exc_enter && !exc_return && !jump_taken) |=>
        (csr_rdata == $past(csr_wdata)) && (block_base == $past(block_base)));  // R6
    AST_RETURN_REDIRECTS: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_return && !exc_enter) |=> redirect_valid && (redirect_addr == $past(csr_rdata)));  // R7
endmodule

// File: tb/sim_ks_resync_tracker.sv
module sim_ks_resync_tracker;
    localparam int IVW  = 2;
    localparam int OFFW = 12;
    localparam logic [31:0] OMASK = 32'hFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        jump_taken = 1'b0, exc_enter = 1'b0, exc_return = 1'b0;
    logic [31:0] jump_target = '0, exc_vector = '0, exc_pc = '0, pc = '0, csr_wdata = '0;
    logic        word_valid = 1'b1, cipher_ready = 1'b1, csr_we = 1'b0;
    logic [31:0] csr_rdata, block_base, redirect_addr;
    logic [11:0] cur_offset;
    logic        redirect_valid, cipher_rekey, word_release, word_discard;

    int checks = 0, errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    ks_resync_tracker #(.AW(32), .OFFW(OFFW), .IV_WORDS(IVW)) u0 (.*);

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural reference: 0 run, 1 iv load, 2 wait ready, 3 drop offset
    int          m_state = 0, m_iv = 0, m_skip = 0;
    logic [31:0] m_base = '0, m_shadow = '0;
    bit          m_rekey = 0, m_redir = 0;

    always @(posedge clk) begin
        logic [31:0] ob, os;
        int off;
        bit prev_rekey;
        if (!rst_n) begin
            m_state = 0; m_iv = 0; m_skip = 0; m_base = '0; m_shadow = '0; m_rekey = 0; m_redir = 0;
        end else begin
            ob = m_base; os = m_shadow; prev_rekey = m_rekey;
            if (exc_enter) m_base = exc_vector;
            else if (exc_return) m_base = os;
            else if (jump_taken) m_base = jump_target;
            if (exc_enter) m_shadow = ob;
            else if (csr_we) m_shadow = csr_wdata;
            if (exc_enter || exc_return || jump_taken) begin
                off = int'(((exc_pc - os) >> 2) & OMASK);
                m_skip  = (exc_return && !exc_enter && off > IVW) ? off - IVW : 0;
                m_state = 1; m_iv = IVW - 1; m_rekey = 0;
                m_redir = exc_return && !exc_enter;
            end else begin
                m_rekey = 0; m_redir = 0;
                case (m_state)
                    1: if (word_valid) begin
                        if (m_iv == 0) begin m_state = 2; m_rekey = 1; end
                        else m_iv--;
                    end
                    2: if (cipher_ready && !prev_rekey) m_state = (m_skip == 0) ? 0 : 3;
                    3: if (word_valid) begin
                        if (m_skip == 1) m_state = 0;
                        m_skip--;
                    end
                    default: ;
                endcase
            end
        end
    end

    always @(negedge clk) begin
        logic [31:0] eoff;
        bit erel, edisc;
        if (!done) begin
            eoff  = ((pc - m_base) >> 2) & OMASK;
            erel  = word_valid && (m_state == 0);
            edisc = word_valid && (m_state == 1 || m_state == 3);
            chk(block_base == m_base, "R2 block_base vs model", block_base, m_base);
            chk(csr_rdata == m_shadow, "R6 csr_rdata vs model", csr_rdata, m_shadow);
            chk(32'(cur_offset) == eoff, "R3 cur_offset vs model", cur_offset, eoff);
            chk(redirect_valid == m_redir, "R7 redirect_valid vs model", redirect_valid, m_redir);
            if (m_redir) chk(redirect_addr == m_base, "R7 redirect_addr vs model", redirect_addr, m_base);
            chk(cipher_rekey == m_rekey, "R8 cipher_rekey vs model", cipher_rekey, m_rekey);
            chk(word_release == erel, "R10 word_release vs model", word_release, erel);
            chk(word_discard == edisc, "R10 word_discard vs model", word_discard, edisc);
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic replay(output int d, output int dr, output bit rv, output logic [31:0] ra);
        d = 0; dr = -1; rv = 0; ra = '0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (redirect_valid) begin rv = 1; ra = redirect_addr; end
            if (cipher_rekey && dr < 0) dr = d;
            if (word_release) break;
            if (word_discard) d++;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int d, dr, nrel, nrk;
        bit rv;
        logic [31:0] ra;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(block_base == 0, "R1 reset block_base", block_base, 0);
        chk(csr_rdata == 0, "R1 reset csr_rdata", csr_rdata, 0);
        chk(!redirect_valid && !cipher_rekey, "R1 reset pulses idle", {redirect_valid, cipher_rekey}, 0);
        chk(word_release == 1'b1, "R1 reset run state releases", word_release, 1);

        tick(); pc = 32'h40;
        @(negedge clk);
        chk(cur_offset == 12'd16, "R3 offset from base 0", cur_offset, 16);

        // plain jump
        tick(); jump_taken = 1; jump_target = 32'h1000;
        tick(); jump_taken = 0;
        replay(d, dr, rv, ra);
        chk(d == 2, "R8 IV words dropped after jump", d, 2);
        chk(dr == 2, "R8 rekey follows IV words", dr, 2);
        chk(block_base == 32'h1000, "R2 jump loads base", block_base, 32'h1000);
        pc = 32'h1010;
        @(negedge clk);
        chk(cur_offset == 12'd4, "R3 offset inside block", cur_offset, 4);

        // exception entry
        tick(); exc_enter = 1; exc_vector = 32'h8000;
        tick(); exc_enter = 0;
        replay(d, dr, rv, ra);
        chk(csr_rdata == 32'h1000, "R4 shadow holds interrupted block", csr_rdata, 32'h1000);
        chk(block_base == 32'h8000, "R4 handler becomes block", block_base, 32'h8000);

        // software write
        tick(); csr_we = 1; csr_wdata = 32'h2000;
        tick(); csr_we = 0;
        @(negedge clk);
        chk(csr_rdata == 32'h2000, "R6 write lands in shadow", csr_rdata, 32'h2000);
        chk(block_base == 32'h8000, "R6 write leaves live base", block_base, 32'h8000);

        // return with a same-cycle write
        tick(); exc_return = 1; exc_pc = 32'h2000 + 28; csr_we = 1; csr_wdata = 32'h3000;
        tick(); exc_return = 0; csr_we = 0;
        replay(d, dr, rv, ra);
        chk(rv && ra == 32'h2000, "R7 redirect to old shadow", ra, 32'h2000);
        chk(d == 7, "R9 IV plus offset words dropped", d, 7);
        chk(block_base == 32'h2000, "R7 base restored", block_base, 32'h2000);
        chk(csr_rdata == 32'h3000, "R7 write after return kept", csr_rdata, 32'h3000);

        // jump and exception entry together
        tick(); jump_taken = 1; jump_target = 32'h500; exc_enter = 1; exc_vector = 32'h9000;
        tick(); jump_taken = 0; exc_enter = 0;
        replay(d, dr, rv, ra);
        chk(block_base == 32'h9000, "R5 entry wins over jump", block_base, 32'h9000);
        chk(csr_rdata == 32'h2000, "R5 shadow takes old base", csr_rdata, 32'h2000);

        // return with offset below the IV count
        tick(); exc_return = 1; exc_pc = 32'h2004;
        tick(); exc_return = 0;
        replay(d, dr, rv, ra);
        chk(d == 2, "R9 small offset drops only IV words", d, 2);
        chk(block_base == 32'h2000, "R9 base after return", block_base, 32'h2000);

        // restart during IV load
        tick(); jump_taken = 1; jump_target = 32'h4000;
        tick(); jump_target = 32'h7000;
        tick(); jump_taken = 0;
        replay(d, dr, rv, ra);
        chk(d == 2, "R11 restart runs full sequence", d, 2);
        chk(block_base == 32'h7000, "R11 latest target kept", block_base, 32'h7000);

        // cipher not ready
        tick(); cipher_ready = 0; jump_taken = 1; jump_target = 32'h5000;
        tick(); jump_taken = 0;
        nrel = 0; nrk = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (word_release) nrel++;
            if (cipher_rekey) nrk++;
        end
        chk(nrel == 0, "R8 no release while cipher busy", nrel, 0);
        chk(nrk == 1, "R8 single rekey pulse", nrk, 1);
        tick(); cipher_ready = 1;
        replay(d, dr, rv, ra);
        chk(d == 0, "R8 release after ready without drops", d, 0);

        tick();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule